// File: doc/BRIEF.md
# Staircase Nearest-Level Gate Pattern Generator

This block turns a stream of signed sinusoidal reference samples into gate enables for a two-stage cascaded switched-ladder inverter with 81 output levels. Each accepted sample is first scaled by an amplitude factor. Its magnitude is then compared against a bank of equally spaced thresholds that sit half a step below each level, so every sample rounds to the nearest level. The comparator outputs are summed into a level magnitude from 0 to 40. Together with the sign of the sample, that magnitude addresses an 81-entry table of 16-bit switch patterns. The selected pattern is split into two eight-gate stage groups and held in registers.

Software or a sequencer fills the pattern table while the gates are disabled, then raises the enable. Lowering the scale lowers the peak level reached, and so the output amplitude, but it never raises it above the rated peak of 40 steps. Both the gates and the signed level index change only on the clock edge that accepts a sample, so a pattern never glitches between two entries.

Top module: `staircase_gate_gen`

## Requirements
- R1: While `rst_ni` is low and after its release, `gates_o` is 0 and `level_o` is 0.
- R2: The scaled magnitude is m = (|ref_i| * scale_i) >> 7. The level magnitude is the count of k in 1..40 for which m >= 800*k - 400. It therefore saturates at 40, and m = 399 gives 0 while m = 400 gives 1.
- R3: `level_o` is a 7-bit two's-complement value equal to +magnitude for ref_i >= 0 and to -magnitude for a negative ref_i. A magnitude of 0 always gives 0.
- R4: `level_o` and `gates_o` take their new values on the first rising edge at which `sample_valid_i` is high, and are visible after that edge. With no strobe, both hold.
- R5: Table addressing works as follows. Level 0 uses entry 0, level +k uses entry k, and level -k uses entry 40+k. When `out_en_i` is high at a strobe, `gates_o` becomes the entry's value as it stood before any write on that same edge.
- R6: A clock edge with `out_en_i` low forces `gates_o` to 0. After the enable rises again, the gates stay 0 until the next strobe.
- R7: A table write (`tbl_we_i`) takes effect only when `out_en_i` is low and `tbl_addr_i` is 80 or less. Any other write leaves the table unchanged.
- R8: After reset, entry 0 holds 16'h7545 (the zero-level pattern) and all other entries hold 0.
- R9: Gate layout: pattern bit n drives `gates_o[n]`. Bits 7:0 belong to stage 1 and bits 15:8 to stage 2. Within a stage, bits 3:0 are the ladder switches, bits 5:4 the bidirectional switches and bits 7:6 the two end switches.
- R10: With scale_i = 128 (unity), a full-scale positive sample gives +40 and -32768 gives -40. Halving the scale halves m.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | Accept the reference sample on this edge |
| ref_i | input | 16 | Signed reference sample |
| scale_i | input | 8 | Amplitude factor, 128 = unity |
| out_en_i | input | 1 | Table valid, gates enabled; writes blocked while high |
| tbl_we_i | input | 1 | Pattern table write strobe |
| tbl_addr_i | input | 7 | Pattern table write address |
| tbl_data_i | input | 16 | Pattern table write data |
| gates_o | output | 16 | Registered gate enables, both stages |
| level_o | output | 7 | Signed level index of the last accepted sample |

## Verification
The bench builds the block with its default values: a 16-bit reference, an 8-bit scale with seven fraction bits and a step of 800. With these values, the sine sweep crosses every positive and negative level. Both threshold edges (399 and 400) can be reached directly, and saturation is reachable at 40 both at unity scale and at the largest scale. A 400-sample period keeps the change per sample below one step, so the sweep also shows that the index moves by no more than one between neighbouring samples.

// File: rtl/sgg_pkg.sv
`timescale 1ns/1ps
package sgg_pkg;
  localparam int unsigned STAGES          = 2;
  localparam int unsigned GATES_PER_STAGE = 8;
  localparam int unsigned NPOS            = 40;
  localparam int unsigned PAT_W           = STAGES * GATES_PER_STAGE;
  localparam int unsigned N_ENTRIES       = 2 * NPOS + 1;
  localparam int unsigned ADDR_W          = $clog2(N_ENTRIES);
  localparam int unsigned LVL_W           = $clog2(NPOS + 1);

  // one stage: ladder in 3:0, bidirectional in 5:4, end switches in 7:6
  typedef struct packed {
    logic [1:0] end_sw;
    logic [1:0] bidir;
    logic [3:0] ladder;
  } stage_gates_t;

  // zero level: stage1 ladder 1,3 + end X; stage2 ladder 1,3 + both bidir + end X
  localparam logic [PAT_W-1:0] ZERO_PAT = 16'h7545;
endpackage

// File: rtl/sgg_level_quant.sv
`timescale 1ns/1ps
module sgg_level_quant
  import sgg_pkg::*;
#(
  parameter int unsigned REF_W      = 16,
  parameter int unsigned SCALE_W    = 8,
  parameter int unsigned SCALE_FRAC = 7,
  parameter int unsigned STEP       = 800
) (
  input  logic signed [REF_W-1:0]   ref_i,
  input  logic        [SCALE_W-1:0] scale_i,
  output logic        [LVL_W-1:0]   mag_o,
  output logic                      neg_o
);
  localparam int unsigned MAG_W  = REF_W + 1;
  localparam int unsigned PROD_W = MAG_W + SCALE_W;

  logic signed [MAG_W-1:0]  ref_ext;
  logic        [MAG_W-1:0]  abs_v;
  logic        [PROD_W-1:0] prod;
  logic        [PROD_W-1:0] scaled;
  logic        [NPOS-1:0]   hits;
  logic        [LVL_W-1:0]  cnt;

  assign ref_ext = {ref_i[REF_W-1], ref_i};
  assign abs_v   = ref_ext[MAG_W-1] ? $unsigned(-ref_ext) : $unsigned(ref_ext);
  assign prod    = PROD_W'(abs_v) * PROD_W'(scale_i);
  assign scaled  = prod >> SCALE_FRAC;

  // thresholds half a step below each level -> nearest-level rounding
  for (genvar k = 0; k < NPOS; k++) begin : g_cmp
    localparam longint unsigned TH = longint'(k + 1) * STEP - STEP / 2;
    assign hits[k] = (scaled >= PROD_W'(TH));
  end

  always_comb begin
    cnt = '0;
    for (int k = 0; k < NPOS; k++) cnt = cnt + LVL_W'(hits[k]);
  end

  assign mag_o = cnt;
  assign neg_o = ref_i[REF_W-1] && (cnt != '0);
endmodule

// File: rtl/sgg_pattern_table.sv
`timescale 1ns/1ps
module sgg_pattern_table
  import sgg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              lock_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [PAT_W-1:0]  wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [PAT_W-1:0]  rdata_o
);
  logic [PAT_W-1:0] mem_q [N_ENTRIES];
  logic             wr_ok;

  assign wr_ok = we_i && !lock_i && (waddr_i < ADDR_W'(N_ENTRIES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < N_ENTRIES; e++) mem_q[e] <= (e == 0) ? ZERO_PAT : '0;
    end else if (wr_ok) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = (raddr_i < ADDR_W'(N_ENTRIES)) ? mem_q[raddr_i] : '0;
endmodule

// File: rtl/sgg_gate_route.sv
`timescale 1ns/1ps
module sgg_gate_route
  import sgg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [PAT_W-1:0] pat_i,
  output logic [PAT_W-1:0] gates_o
);
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    stage_gates_t sel;
    stage_gates_t q;

    assign sel = stage_gates_t'(pat_i[s*GATES_PER_STAGE +: GATES_PER_STAGE]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q <= '0;
      else if (!en_i)   q <= '0;
      else if (load_i)  q <= sel;
    end

    assign gates_o[s*GATES_PER_STAGE +: GATES_PER_STAGE] = q;
  end
endmodule

// File: rtl/staircase_gate_gen.sv
`timescale 1ns/1ps
module staircase_gate_gen
  import sgg_pkg::*;
#(
  parameter int unsigned REF_W      = 16,
  parameter int unsigned SCALE_W    = 8,
  parameter int unsigned SCALE_FRAC = 7,
  parameter int unsigned STEP       = 800
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      sample_valid_i,
  input  logic signed [REF_W-1:0]   ref_i,
  input  logic        [SCALE_W-1:0] scale_i,
  input  logic                      out_en_i,
  input  logic                      tbl_we_i,
  input  logic        [ADDR_W-1:0]  tbl_addr_i,
  input  logic        [PAT_W-1:0]   tbl_data_i,
  output logic        [PAT_W-1:0]   gates_o,
  output logic signed [LVL_W:0]     level_o
);
  logic [LVL_W-1:0]  mag;
  logic              neg;
  logic [ADDR_W-1:0] raddr;
  logic [PAT_W-1:0]  pat;
  logic signed [LVL_W:0] level_q;
  logic signed [LVL_W:0] mag_s;

  sgg_level_quant #(
    .REF_W(REF_W), .SCALE_W(SCALE_W), .SCALE_FRAC(SCALE_FRAC), .STEP(STEP)
  ) u_quant (
    .ref_i  (ref_i),
    .scale_i(scale_i),
    .mag_o  (mag),
    .neg_o  (neg)
  );

  // entry 0 zero, 1..NPOS positive, NPOS+1..2*NPOS negative
  always_comb begin
    if (mag == '0)  raddr = '0;
    else if (neg)   raddr = ADDR_W'(NPOS) + ADDR_W'(mag);
    else            raddr = ADDR_W'(mag);
  end

  sgg_pattern_table u_table (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (tbl_we_i),
    .lock_i (out_en_i),
    .waddr_i(tbl_addr_i),
    .wdata_i(tbl_data_i),
    .raddr_i(raddr),
    .rdata_o(pat)
  );

  sgg_gate_route u_route (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (out_en_i),
    .load_i (sample_valid_i),
    .pat_i  (pat),
    .gates_o(gates_o)
  );

  assign mag_s = $signed({1'b0, mag});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             level_q <= '0;
    else if (sample_valid_i) level_q <= neg ? -mag_s : mag_s;
  end

  assign level_o = level_q;
endmodule

// File: rtl/sgg_checker.sv
`timescale 1ns/1ps
module sgg_checker
  import sgg_pkg::*;
#(
  parameter int unsigned REF_W      = 16,
  parameter int unsigned SCALE_W    = 8,
  parameter int unsigned SCALE_FRAC = 7,
  parameter int unsigned STEP       = 800
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      sample_valid_i,
  input logic signed [REF_W-1:0]   ref_i,
  input logic        [SCALE_W-1:0] scale_i,
  input logic                      out_en_i,
  input logic        [PAT_W-1:0]   gates_o,
  input logic signed [LVL_W:0]     level_o
);
  localparam logic signed [REF_W-1:0] REF_MAX = {1'b0, {(REF_W-1){1'b1}}};
  localparam logic [SCALE_W-1:0]      UNITY   = SCALE_W'(1 << SCALE_FRAC);

  p_level_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o <= $signed((LVL_W+1)'(NPOS))) && (level_o >= -$signed((LVL_W+1)'(NPOS))));

  p_gates_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en_i |=> (gates_o == '0));

  p_level_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_i |=> $stable(level_o));

  p_gates_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_en_i && !sample_valid_i) |=> $stable(gates_o));

  p_zero_ref_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && ref_i == '0) |=> (level_o == '0));

  p_saturate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && ref_i == REF_MAX && scale_i >= UNITY)
      |=> (level_o == $signed((LVL_W+1)'(NPOS))));
endmodule

bind staircase_gate_gen sgg_checker #(
  .REF_W(REF_W), .SCALE_W(SCALE_W), .SCALE_FRAC(SCALE_FRAC), .STEP(STEP)
) u_sgg_checker (.*);

// File: tb/tb_staircase_gate_gen.sv
`timescale 1ns/1ps
module tb_staircase_gate_gen;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               sv = 1'b0;
  logic signed [15:0] refv = '0;
  logic [7:0]         scale = 8'd128;
  logic               en = 1'b0;
  logic               we = 1'b0;
  logic [6:0]         waddr = '0;
  logic [15:0]        wdata = '0;
  logic [15:0]        gates;
  logic signed [6:0]  level;

  int n_checks = 0;
  int n_err    = 0;
  int cyc      = 0;
  bit done     = 0;
  string cur_req = "R1";

  // behavioural model state
  int tbl [81];
  int exp_gates = 0;
  int exp_level = 0;

  always #4 clk = ~clk;

  staircase_gate_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .sample_valid_i(sv), .ref_i(refv),
    .scale_i(scale), .out_en_i(en), .tbl_we_i(we), .tbl_addr_i(waddr),
    .tbl_data_i(wdata), .gates_o(gates), .level_o(level)
  );

  function automatic int model_level(int r, int sc);
    longint a = (r < 0) ? -r : r;
    longint m = (a * sc) / 128;
    int c = 0;
    for (int k = 1; k <= 40; k++) if (m >= longint'(800 * k - 400)) c++;
    return (r < 0) ? -c : c;
  endfunction

  function automatic int model_addr(int lv);
    if (lv == 0) return 0;
    return (lv > 0) ? lv : 40 - lv;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < 81; e++) tbl[e] = (e == 0) ? 32'h7545 : 0;
      exp_gates = 0;
      exp_level = 0;
    end else begin
      int lv;
      lv = model_level(int'(refv), int'(scale));
      if (!en) exp_gates = 0;
      else if (sv) exp_gates = tbl[model_addr(lv)];
      if (sv) exp_level = lv;
      if (we && !en && waddr <= 7'd80) tbl[waddr] = int'(wdata);
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({cur_req, " gates"}, int'(gates), exp_gates);
      chk({cur_req, " level"}, int'(level), exp_level);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000 && !done) begin
      done = 1;
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  function automatic int pat_of(int a);
    return ((a * 40503) ^ 16'h3c5a) & 16'hffff;
  endfunction

  task automatic sample(int r, int sc);
    @(negedge clk);
    refv = 16'(r); scale = 8'(sc); sv = 1'b1;
    @(negedge clk);
    sv = 1'b0;
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    we = 1'b1; waddr = 7'(a); wdata = 16'(d);
    @(negedge clk);
    we = 1'b0;
  endtask

  initial begin
    int prev;
    repeat (3) @(negedge clk);
    chk("R1 reset gates", int'(gates), 0);
    chk("R1 reset level", int'(level), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", int'(gates), 0);

    // R8 zero pattern present from reset
    cur_req = "R8";
    en = 1'b1;
    sample(0, 128);
    chk("R8 zero entry", int'(gates), 16'h7545);
    chk("R9 stage2 bidir bits 13:12", int'(gates[13:12]), 3);

    // R6 disable forces off, re-enable keeps off until strobe
    cur_req = "R6";
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    chk("R6 disabled", int'(gates), 0);
    en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 stays off", int'(gates), 0);

    // load table
    cur_req = "R7";
    en = 1'b0;
    for (int a = 0; a < 81; a++) wr(a, pat_of(a));
    wr(81, 16'hffff);
    wr(127, 16'hffff);
    en = 1'b1;
    wr(5, 16'hffff); // blocked
    sample(4000, 128);
    chk("R7 locked write ignored", int'(gates), pat_of(5));
    chk("R2 level 5", int'(level), 5);

    // R2 threshold edges
    cur_req = "R2";
    sample(399, 128);
    chk("R2 m=399", int'(level), 0);
    sample(400, 128);
    chk("R2 m=400", int'(level), 1);
    chk("R5 entry 1", int'(gates), pat_of(1));

    // R3/R5 negative bank
    cur_req = "R3";
    sample(-400, 128);
    chk("R3 level -1", int'(level), -1);
    chk("R5 entry 41", int'(gates), pat_of(41));
    sample(-399, 128);
    chk("R3 neg zero", int'(level), 0);
    chk("R5 neg zero entry 0", int'(gates), pat_of(0));

    // R10 saturation and scaling
    cur_req = "R10";
    sample(32767, 128);
    chk("R10 +full", int'(level), 40);
    sample(-32768, 128);
    chk("R10 -full", int'(level), -40);
    chk("R5 entry 80", int'(gates), pat_of(80));
    sample(32767, 255);
    chk("R10 over-unity clamps", int'(level), 40);
    sample(16000, 64);
    chk("R10 half scale", int'(level), 10);

    // R4 hold without strobe
    cur_req = "R4";
    refv = 16'sd20000;
    repeat (4) @(negedge clk);
    chk("R4 level held", int'(level), 10);

    // full sine sweep, 400 samples per period
    cur_req = "R2 sweep";
    prev = int'(level);
    sample(0, 128);
    prev = int'(level);
    for (int i = 1; i <= 400; i++) begin
      int r;
      r = $rtoi(32000.0 * $sin(2.0 * 3.14159265358979 * i / 400.0));
      sample(r, 128);
      n_checks++;
      if ((int'(level) - prev > 1) || (prev - int'(level) > 1)) begin
        n_err++;
        $display("FAIL R2 adjacency: actual %0d expected within 1 of %0d", int'(level), prev);
      end
      prev = int'(level);
    end

    // reduced amplitude sweep
    cur_req = "R10 sweep";
    for (int i = 0; i < 100; i++)
      sample($rtoi(32000.0 * $sin(2.0 * 3.14159265358979 * i / 100.0)), 40);

    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule